// File: doc/BRIEF.md
# Interrupt Level Encoder and Acknowledge Decoder

This block links seven peripheral interrupt request lines to a processor that takes a three-bit encoded priority level. It also decodes the processor's interrupt acknowledge bus cycles and sends a strobe back to the peripheral being serviced. Each request input is active low. Each request passes through a two-stage synchroniser. A priority encoder then drives the encoded level pins. These pins are active low, so when all three are high no interrupt is pending.

The acknowledge half watches the function code, the level the processor places on address lines 3 to 1, and the address strobe. When the function code marks an acknowledge cycle and the strobe is low, the block pulls low the one acknowledge line that matches the level on the address. Function codes for ordinary program and data accesses never produce a strobe. A level of zero on the address never produces a strobe either. All outputs are registered.

Top module: `irq_glue`

## Requirements
- R1: While reset is high, and on the first edge after it falls, the level pins read 111 and all seven acknowledge lines read high.
- R2: The level pins carry the bitwise inverse of the highest numbered asserted request. Request input bit k (0 to 6) is level k+1, and level 7 wins over every other level.
- R3: With no request asserted, the level pins read 111 (level 0).
- R4: A change on the request inputs reaches the level pins on the third rising edge after it is set up, and not before. This allows two synchroniser stages and one output register.
- R5: When the function code is 111, the address strobe is low and the address level L is between 1 and 7, acknowledge bit L-1 goes low on the next rising edge.
- R6: At most one acknowledge line is low at any time.
- R7: Function codes 000 to 110, including 001, 010, 101 and 110 (program and data accesses), never drive an acknowledge line low.
- R8: An address level of 000 during an acknowledge-type function code drives no acknowledge line low.
- R9: When the address strobe is high, all acknowledge lines are high from the next rising edge, whatever the function code and address.
- R10: Acknowledge decoding does not depend on which requests are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 7 | Interrupt requests, active low, bit k = level k+1 |
| fc | input | 3 | Processor function code |
| addr_lvl | input | 3 | Address lines 3 to 1, the level being acknowledged |
| as_n | input | 1 | Address strobe, active low |
| ipl_n | output | 3 | Encoded request level, active low |
| iack_n | output | 7 | Acknowledge strobes, active low, bit k = level k+1 |

## Verification
The bench covers the following corner cases:

- **Competing levels.** It asserts several requests at once, including level 7 with lower levels and level 1 alone. An encoder that scans in the wrong direction would then report a lower level than the one that should win.
- **Request latency.** It samples the level pins after two edges and again after three. A synchroniser with a stage missing or added would show up as an early or late change.
- **Acknowledge qualification.** It sweeps every function code, address levels 0 to 7, and the strobe high. A decoder that ignored the function code would acknowledge on ordinary accesses. One that ignored the strobe would hold a line low. One that mapped level 0 would wrap onto a real line.
- **Independence.** It repeats acknowledge cycles with requests pending to show that the two halves do not interact.

// File: rtl/irqg_pkg.sv
`timescale 1ns/1ps
package irqg_pkg;
  // number of prioritised request levels and function code width
  parameter int unsigned LEVELS_DEF = 7;
  parameter int unsigned FC_W_DEF   = 3;

  // function code meanings relevant to acknowledge qualification
  typedef enum logic [2:0] {
    FC_USR_DATA = 3'b001,
    FC_USR_PROG = 3'b010,
    FC_SUP_DATA = 3'b101,
    FC_SUP_PROG = 3'b110,
    FC_ACK      = 3'b111
  } fc_e;
endpackage

// File: rtl/irqg_sync.sv
`timescale 1ns/1ps
module irqg_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_n,
  output logic [WIDTH-1:0] q_n
);
  // each line gets its own chain, reset to the idle (high) level
  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_n[b]};
    end
    assign q_n[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/irqg_prio.sv
`timescale 1ns/1ps
module irqg_prio #(
  parameter int unsigned LEVELS = 7,
  localparam int unsigned LW    = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] req_n,
  output logic [LW-1:0]     ipl_n
);
  logic [LW-1:0] top_lvl;

  // scan upward so the highest asserted level is the last to win
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (!req_n[i]) top_lvl = LW'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ipl_n <= '1;
    else     ipl_n <= ~top_lvl;
  end

  // R3: nothing requested means all level pins high next cycle
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (&req_n) |=> (&ipl_n));

  // R2: the top level dominates whatever else is asserted
  a_r2_top_wins: assert property (@(posedge clk) disable iff (rst)
    (!req_n[LEVELS-1]) |=> (ipl_n == ~LW'(LEVELS)));

  // R2: lowest level alone is reported as level 1
  a_r2_low_alone: assert property (@(posedge clk) disable iff (rst)
    (req_n == {{(LEVELS-1){1'b1}}, 1'b0}) |=> (ipl_n == ~LW'(1)));
endmodule

// File: rtl/irqg_ackdec.sv
`timescale 1ns/1ps
module irqg_ackdec
  import irqg_pkg::*;
#(
  parameter int unsigned LEVELS = 7,
  parameter int unsigned FC_W   = 3,
  localparam int unsigned LW    = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FC_W-1:0]   fc,
  input  logic [LW-1:0]     lvl,
  input  logic              as_n,
  output logic [LEVELS-1:0] iack_n
);
  logic              ack_cycle;
  logic [LEVELS-1:0] hit;

  assign ack_cycle = (fc == FC_W'(FC_ACK)) && !as_n;

  // one comparator per acknowledge line; level 0 matches none
  for (genvar g = 0; g < LEVELS; g++) begin : g_cmp
    assign hit[g] = ack_cycle && (lvl == LW'(g + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) iack_n <= '1;
    else     iack_n <= ~hit;
  end

  // R6: never more than one acknowledge line low
  a_r6_single_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~iack_n));

  // R7: non-acknowledge function codes give no strobe
  a_r7_fc_block: assert property (@(posedge clk) disable iff (rst)
    (fc != FC_W'(FC_ACK)) |=> (&iack_n));

  // R9: strobe high releases every acknowledge line
  a_r9_strobe_release: assert property (@(posedge clk) disable iff (rst)
    as_n |=> (&iack_n));

  // R8: level zero on the address gives no strobe
  a_r8_level_zero: assert property (@(posedge clk) disable iff (rst)
    (lvl == '0) |=> (&iack_n));

  // R5: the matching line goes low one edge later
  a_r5_match: assert property (@(posedge clk) disable iff (rst)
    (ack_cycle && lvl != '0) |=> ((~iack_n) == (LEVELS'(1) << ($past(lvl) - LW'(1)))));
endmodule

// File: rtl/irq_glue.sv
`timescale 1ns/1ps
module irq_glue
  import irqg_pkg::*;
#(
  parameter int unsigned LEVELS      = LEVELS_DEF,
  parameter int unsigned FC_W        = FC_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LW         = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] req_n,
  input  logic [FC_W-1:0]   fc,
  input  logic [LW-1:0]     addr_lvl,
  input  logic              as_n,
  output logic [LW-1:0]     ipl_n,
  output logic [LEVELS-1:0] iack_n
);
  logic [LEVELS-1:0] req_sync_n;

  irqg_sync #(.WIDTH(LEVELS), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_n (req_n),
    .q_n (req_sync_n)
  );

  irqg_prio #(.LEVELS(LEVELS)) i_prio (
    .clk   (clk),
    .rst   (rst),
    .req_n (req_sync_n),
    .ipl_n (ipl_n)
  );

  irqg_ackdec #(.LEVELS(LEVELS), .FC_W(FC_W)) i_ackdec (
    .clk    (clk),
    .rst    (rst),
    .fc     (fc),
    .lvl    (addr_lvl),
    .as_n   (as_n),
    .iack_n (iack_n)
  );
endmodule

// File: tb/test_irq_glue.sv
`timescale 1ns/1ps
module test_irq_glue;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req_n = 7'h7f;
  logic [2:0] fc = 3'b000;
  logic [2:0] addr_lvl = 3'b000;
  logic       as_n = 1'b1;
  logic [2:0] ipl_n;
  logic [6:0] iack_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [2:0] ipl;
    logic [6:0] ack;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  irq_glue i_irq_glue (
    .clk(clk), .rst(rst), .req_n(req_n), .fc(fc),
    .addr_lvl(addr_lvl), .as_n(as_n), .ipl_n(ipl_n), .iack_n(iack_n)
  );

  function automatic logic [2:0] exp_ipl(input logic [6:0] r);
    for (int l = 7; l >= 1; l--) if (!r[l-1]) return ~3'(l);
    return 3'b111;
  endfunction

  function automatic logic [6:0] exp_ack(input logic [2:0] f, input logic [2:0] a, input logic s);
    if (f == 3'b111 && !s && a != 3'd0) return ~(7'd1 << (a - 3'd1));
    return 7'h7f;
  endfunction

  // monitor: pops one expected item per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        exp_t it;
        it = sbq.pop_front();
        total++;
        if (ipl_n !== it.ipl || iack_n !== it.ack) begin
          bad++;
          $display("FAIL %s: ipl_n=%b iack_n=%b expected ipl_n=%b iack_n=%b",
                   it.tag, ipl_n, iack_n, it.ipl, it.ack);
        end
      end
    end
  end

  logic [6:0] cur_req = 7'h7f;

  // driver: applies one input set and queues the expected result per edge
  task automatic step(input logic [6:0] r, input logic [2:0] f, input logic [2:0] a,
                      input logic s, input string tag);
    logic [6:0] old_r;
    old_r = cur_req;
    @(negedge clk);
    #2;
    req_n = r; fc = f; addr_lvl = a; as_n = s;
    cur_req = r;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      // R4: request path visible on the third edge only
      sbq.push_back('{ipl: (k >= 3) ? exp_ipl(r) : exp_ipl(old_r),
                      ack: exp_ack(f, a, s), tag: tag});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (ipl_n !== 3'b111 || iack_n !== 7'h7f) begin
      bad++;
      $display("FAIL R1: ipl_n=%b iack_n=%b expected 111 1111111", ipl_n, iack_n);
    end
    rst = 1'b0;
    @(posedge clk); #1;
    sbq.push_back('{ipl: 3'b111, ack: 7'h7f, tag: "R1"});

    step(7'h7f, 3'b000, 3'd0, 1'b1, "R3");
    step(7'b1111110, 3'b000, 3'd0, 1'b1, "R2_level1");
    step(7'b1111011, 3'b000, 3'd0, 1'b1, "R4_change");
    step(7'b0101010, 3'b000, 3'd0, 1'b1, "R2_level7_wins");
    step(7'b1010101, 3'b000, 3'd0, 1'b1, "R2_mixed");
    step(7'b1101111, 3'b000, 3'd0, 1'b1, "R2_level5");
    step(7'h7f, 3'b000, 3'd0, 1'b1, "R3_release");
    for (int l = 1; l <= 7; l++) step(7'h7f, 3'b111, 3'(l), 1'b0, "R5_R6");
    for (int f = 0; f <= 6; f++) step(7'h7f, 3'(f), 3'd3, 1'b0, "R7");
    step(7'h7f, 3'b111, 3'd0, 1'b0, "R8");
    step(7'h7f, 3'b111, 3'd6, 1'b1, "R9");
    step(7'h7f, 3'b111, 3'd2, 1'b0, "R5_again");
    step(7'h7f, 3'b111, 3'd2, 1'b1, "R9_release");
    step(7'b0111111, 3'b111, 3'd1, 1'b0, "R10");
    step(7'b0000000, 3'b111, 3'd4, 1'b0, "R10_all");
    step(7'b0000000, 3'b110, 3'd4, 1'b0, "R10_R7");
    step(7'h7f, 3'b000, 3'd0, 1'b1, "R3_end");
    @(posedge clk); @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule